// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block holds the program counter of a single-cycle processor and chooses the address of the next instruction on every clock. It supports three paths: the sequential step to the following word, a PC-relative conditional branch, and a pseudo-direct jump. A jump keeps the four most significant bits of the current PC and replaces the remaining bits with a word-aligned 26-bit target.

The decoder drives `branch_i` for any branch instruction. That flag does not select the mux by itself. The branch is taken only when the datapath's equality result `zero_i` is also high. The current PC on `pc_o` addresses instruction memory.

Top module: `fetch_npc`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0. The reset is asynchronous, so the PC reads 0 without waiting for a clock edge.
- R2: At a rising clock edge with `jump_i` low and `branch_i` low, the PC advances by 4.
- R3: At a rising clock edge with `branch_i`, `zero_i` high and `jump_i` low, the next PC is PC + 4 + (sign-extended `imm_i` shifted left by 2).
- R4: When `branch_i` is high and `zero_i` is low, with `jump_i` low, the branch is not taken and the PC advances by 4.
- R5: When `zero_i` is high and `branch_i` is low, with `jump_i` low, the PC advances by 4. The zero flag alone has no effect.
- R6: When `jump_i` is high, the next PC is {PC[31:28], `target_i`, 2'b00}.
- R7: When `jump_i` and a taken branch are both requested in the same cycle, the jump wins.
- R8: Bits [1:0] of `pc_o` are always 0.
- R9: Branch arithmetic wraps modulo 2^32. Bit 15 of `imm_i` is the sign, so a negative offset moves the PC backward, including across address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the PC updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the PC with 0 |
| branch_i | input | 1 | The current instruction is a conditional branch |
| zero_i | input | 1 | Equality result from the ALU |
| jump_i | input | 1 | The current instruction is a jump |
| imm_i | input | 16 | Signed branch offset, in words |
| target_i | input | 26 | Word index of the jump target inside the current 256 MB region |
| pc_o | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is a jump that carries nonzero upper PC bits. Reset leaves those bits at 0, and sequential stepping would need far too many cycles to change them. The stimulus takes a large negative branch from near address 0, which wraps the PC into the top of the address space. It then jumps, so the four kept bits are all ones. Large positive branches and a jump issued together with a taken branch cover the carry out of the offset adder and the priority order.

// File: rtl/fnpc_pkg.sv
package fnpc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_JMP = 2'd2
  } npc_src_e;
endpackage

// File: rtl/fnpc_incr.sv
module fnpc_incr #(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2
) (
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] seq_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;
  assign seq_o = pc_i + STEP;
endmodule

// File: rtl/fnpc_branch_tgt.sv
module fnpc_branch_tgt #(
  parameter int PC_W  = 32,
  parameter int IMM_W = 16,
  parameter int ALIGN = 2
) (
  input  logic [PC_W-1:0]  seq_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [PC_W-1:0]  br_o
);
  localparam int EXT_W = PC_W - IMM_W - ALIGN;
  logic [PC_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN{1'b0}}};
    end else begin : g_trunc
      assign offset = PC_W'({imm_i, {ALIGN{1'b0}}});
    end
  endgenerate

  // modulo 2^PC_W by width
  assign br_o = seq_i + offset;
endmodule

// File: rtl/fnpc_jump_tgt.sv
module fnpc_jump_tgt #(
  parameter int PC_W  = 32,
  parameter int TGT_W = 26,
  parameter int ALIGN = 2
) (
  input  logic [PC_W-TGT_W-ALIGN-1:0] hi_i,
  input  logic [TGT_W-1:0]            tgt_i,
  output logic [PC_W-1:0]             jmp_o
);
  assign jmp_o = {hi_i, tgt_i, {ALIGN{1'b0}}};
endmodule

// File: rtl/fnpc_sel.sv
module fnpc_sel
  import fnpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            branch_i,
  input  logic            zero_i,
  input  logic            jump_i,
  input  logic [PC_W-1:0] seq_i,
  input  logic [PC_W-1:0] br_i,
  input  logic [PC_W-1:0] jmp_i,
  output npc_src_e        src_o,
  output logic [PC_W-1:0] npc_o
);
  logic taken;
  assign taken = branch_i & zero_i;

  always_comb begin
    if (jump_i)     src_o = NPC_JMP;
    else if (taken) src_o = NPC_BR;
    else            src_o = NPC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      NPC_JMP: npc_o = jmp_i;
      NPC_BR:  npc_o = br_i;
      default: npc_o = seq_i;
    endcase
  end
endmodule

// File: rtl/fetch_npc.sv
module fetch_npc
  import fnpc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             branch_i,
  input  logic             zero_i,
  input  logic             jump_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  output logic [PC_W-1:0]  pc_o
);
  localparam int ALIGN = 2;
  localparam int HI_W  = PC_W - TGT_W - ALIGN;
  localparam int WRD_W = PC_W - ALIGN;

  // only word bits are stored; low bits tie to 0
  logic [WRD_W-1:0] pc_q;
  logic [PC_W-1:0]  seq_pc, br_pc, jmp_pc, npc;
  npc_src_e         src;

  assign pc_o = {pc_q, {ALIGN{1'b0}}};

  fnpc_incr #(.PC_W(PC_W), .ALIGN(ALIGN)) u_incr (
    .pc_i  (pc_o),
    .seq_o (seq_pc)
  );

  fnpc_branch_tgt #(.PC_W(PC_W), .IMM_W(IMM_W), .ALIGN(ALIGN)) u_br (
    .seq_i (seq_pc),
    .imm_i (imm_i),
    .br_o  (br_pc)
  );

  fnpc_jump_tgt #(.PC_W(PC_W), .TGT_W(TGT_W), .ALIGN(ALIGN)) u_jmp (
    .hi_i  (pc_o[PC_W-1 -: HI_W]),
    .tgt_i (target_i),
    .jmp_o (jmp_pc)
  );

  fnpc_sel #(.PC_W(PC_W)) u_sel (
    .branch_i (branch_i),
    .zero_i   (zero_i),
    .jump_i   (jump_i),
    .seq_i    (seq_pc),
    .br_i     (br_pc),
    .jmp_i    (jmp_pc),
    .src_o    (src),
    .npc_o    (npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= npc[PC_W-1:ALIGN];
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> pc_o == '0); // R1

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !branch_i) |=> pc_o == $past(pc_o) + PC_W'(4)); // R2

  AST_NO_BRANCH_WO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && branch_i && !zero_i) |=> pc_o == $past(pc_o) + PC_W'(4)); // R4

  AST_ZERO_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !branch_i && zero_i) |=> pc_o == $past(pc_o) + PC_W'(4)); // R5

  AST_BRANCH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && branch_i && zero_i) |=>
      pc_o == $past(pc_o) + PC_W'(4) +
              {{(PC_W-IMM_W-ALIGN){$past(imm_i[IMM_W-1])}}, $past(imm_i), {ALIGN{1'b0}}}); // R3

  AST_JUMP_HI_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> pc_o[PC_W-1 -: HI_W] == $past(pc_o[PC_W-1 -: HI_W])); // R6

  AST_JUMP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && branch_i && zero_i) |=> pc_o[PC_W-HI_W-1:0] == {$past(target_i), {ALIGN{1'b0}}}); // R7

  AST_NPC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc[ALIGN-1:0] == '0); // R8
endmodule

// File: tb/fetch_npc_bench.sv
`timescale 1ns/1ps
module fetch_npc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        branch_i = 1'b0, zero_i = 1'b0, jump_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic [31:0] pc_o;

  typedef struct {
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model_pc = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  fetch_npc u_fetch_npc (
    .clk_i(clk_i), .rst_ni(rst_ni), .branch_i(branch_i), .zero_i(zero_i),
    .jump_i(jump_i), .imm_i(imm_i), .target_i(target_i), .pc_o(pc_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_pc(logic [31:0] pc, logic br, logic z,
                                          logic j, logic [15:0] imm, logic [25:0] tgt);
    if (j)            return {pc[31:28], tgt, 2'b00};
    else if (br && z) return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else              return pc + 32'd4;
  endfunction

  // driver: apply stimulus now, push expectation, move to next negedge
  task automatic step(input logic br, input logic z, input logic j,
                      input logic [15:0] imm, input logic [25:0] tgt, input string tag);
    exp_t it;
    branch_i = br; zero_i = z; jump_i = j; imm_i = imm; target_i = tgt;
    it.pc  = next_pc(model_pc, br, z, j, imm, tgt);
    it.tag = tag;
    model_pc = it.pc;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check(pc_o === it.pc, it.tag, pc_o, it.pc);
        check(pc_o[1:0] === 2'b00, "R8", {30'd0, pc_o[1:0]}, 32'd0);
      end
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #1;
    check(pc_o === 32'd0, "R1", pc_o, 32'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 16'h0000, '0, "R2");
    step(0, 0, 0, 16'hffff, 26'h3ffffff, "R2");
    step(1, 1, 0, 16'h0005, '0, "R3");
    step(1, 0, 0, 16'h0040, '0, "R4");
    step(0, 1, 0, 16'h0040, '0, "R5");
    step(1, 1, 0, 16'hffff, '0, "R9");     // net zero move
    step(1, 1, 0, 16'hfffc, '0, "R9");     // backward
    step(1, 1, 0, 16'h8000, '0, "R9");     // wraps below 0
    step(0, 0, 1, 16'h0000, 26'h1234567, "R6");
    step(1, 1, 0, 16'h7fff, '0, "R3");
    step(1, 1, 1, 16'h0100, 26'h00000aa, "R7");
    step(1, 1, 1, 16'h8000, 26'h3ffffff, "R7");
    step(0, 0, 0, 16'h0000, '0, "R2");
    step(0, 0, 1, 16'h0000, 26'h0000000, "R6");
    step(1, 1, 0, 16'h7fff, '0, "R3");
    step(1, 1, 0, 16'h7fff, '0, "R9");
    step(0, 0, 0, 16'h0000, '0, "R2");
    branch_i = 0; zero_i = 0; jump_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    // asynchronous reset mid-run, with a jump pending
    jump_i = 1; target_i = 26'h2aaaaaa;
    #1 rst_ni = 1'b0;
    #0.5;
    check(pc_o === 32'd0, "R1", pc_o, 32'd0);
    @(negedge clk_i);
    check(pc_o === 32'd0, "R1", pc_o, 32'd0);
    model_pc = '0;
    rst_ni = 1'b1;
    step(0, 0, 1, 16'h0000, 26'h2aaaaaa, "R6");
    step(0, 1, 0, 16'h1000, '0, "R5");
    branch_i = 0; zero_i = 0; jump_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule